// File: doc/BRIEF.md
# Warp Operand Scoreboard with Dual-Path Writeback Arbitration

This block sits between decode and the functional units of a multi-warp core. It keeps one ready bit per architectural register for every warp. It holds a single issue slot, and it sends the instruction in that slot either to the execute path or to the load/store path once the instruction's source registers are ready. When an instruction dispatches with a destination, that destination's ready bit is cleared. The bit is set again when the result passes the single writeback port. Register 0 never blocks anything.

The execute path is never busy, and its results always win the writeback port. A finished load whose result loses the port stays in the load/store unit for another cycle. While it waits there, it blocks the next memory dispatch. Each memory instruction carries its own latency. That latency is loaded into a down-counter when the instruction dispatches. The counter must reach zero before the result can be written back. The writeback record marks its origin and carries a warp-release flag, so fetch can wake a warp that was held on a control instruction. Each cycle the logic is evaluated from writeback back to issue. As a result, a result written back, a load/store unit freed or a slot emptied is usable in that same cycle.

Top module: `warp_issue_sb`

## Requirements
- R1: After reset every register of every warp is ready, the slot is empty, and issue_stall, both dispatch valids and wb_valid are 0. The first instruction accepted after reset dispatches in the next cycle, even when its nonzero sources name the highest register.
- R2: A source register number of 0 is never checked. It never stalls the slot, even right after an instruction of the same warp names register 0 as its destination.
- R3: Dispatch of an instruction with in_rd_en=1 clears the ready bit of (warp, rd). A later instruction of the same warp that reads that register stalls. Instructions of other warps that read the same register number do not stall.
- R4: A writeback record with wb_rd_en=1 and wb_rd>0 makes that register ready. A reader stalled on that register dispatches in the same cycle the record is visible.
- R5: A non-memory instruction with ready sources asserts exe_disp_valid in the cycle after it enters the slot. Its writeback record is visible two cycles after dispatch.
- R6: A memory instruction does not dispatch while the load/store unit has remaining latency or holds a result that lost the writeback port. issue_stall is 1 during that time.
- R7: An execute result produces a writeback record (wb_from_mem=0) only if it has a destination greater than 0 or has in_release=1. A result with neither produces no record.
- R8: A load/store result produces a record (wb_from_mem=1) only when its latency count is zero and it has a destination greater than 0. Stores and loads to register 0 produce no record.
- R9: When an execute result and a finished load compete for the port in the same cycle, the execute result is written first. The load is written in the next cycle.
- R10: A memory instruction dispatched in cycle d with latency L has its count reach zero in cycle d+1+L. Its record is visible in cycle d+2+L.
- R11: The slot accepts a new instruction on the same edge on which its current one dispatches. While issue_stall is 1, in_valid is ignored and the slot keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction offered to the issue slot |
| in_wid | input | WID_W | Warp of the offered instruction |
| in_rs1 | input | REG_W | First source register |
| in_rs2 | input | REG_W | Second source register |
| in_rd_en | input | 1 | Instruction has a destination |
| in_rd | input | REG_W | Destination register |
| in_is_mem | input | 1 | Instruction goes to the load/store path |
| in_release | input | 1 | Result releases a held warp |
| in_mem_lat | input | LAT_W | Remaining memory latency, loaded when the instruction dispatches |
| issue_stall | output | 1 | Slot holds an instruction that cannot dispatch |
| exe_disp_valid | output | 1 | Slot dispatches to the execute path this cycle |
| mem_disp_valid | output | 1 | Slot dispatches to the load/store path this cycle |
| wb_valid | output | 1 | Writeback record valid |
| wb_wid | output | WID_W | Warp of the record |
| wb_rd_en | output | 1 | Record writes a register |
| wb_rd | output | REG_W | Register written |
| wb_release | output | 1 | Record releases its warp |
| wb_from_mem | output | 1 | Record came from the load/store path |

## Verification
The bench builds the block with 4 warps, 8 registers and a 4-bit latency field. With these values, warp and register fields can be driven with exact values that are easy to check by hand. Registers 0 and 7 then cover both ends of the register range, and distinct warps show that readiness is kept separately per warp. The short latency field keeps the load/store countdown within a few cycles. With those short countdowns, a finished load can be made to collide with an execute result, and a third memory instruction can be queued behind the blocked load.

// File: rtl/sbi_pkg.sv
// Shared types for the warp scoreboard issue block.
// Assumes: nothing beyond standard SystemVerilog.
package sbi_pkg;
    // Origin of the record loaded into the writeback register.
    typedef enum logic [1:0] {
        WB_IDLE     = 2'd0,
        WB_FROM_EXE = 2'd1,
        WB_FROM_MEM = 2'd2
    } wb_src_e;
endpackage

// File: rtl/sbi_ready_table.sv
// Per-warp register ready bits with a same-cycle writeback bypass.
// What it does: answers whether both sources of the queried warp are ready,
// sets bits from the writeback record and clears them on dispatch.
// Assumes: NUM_WARPS and NUM_REGS are powers of two; clear wins over set.
module sbi_ready_table #(
    parameter int NUM_WARPS = 32,
    parameter int NUM_REGS  = 32,
    parameter int WID_W     = 5,
    parameter int REG_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WID_W-1:0] q_wid,
    input  logic [REG_W-1:0] q_rs1,
    input  logic [REG_W-1:0] q_rs2,
    output logic             q_ok,
    input  logic             set_en,
    input  logic [WID_W-1:0] set_wid,
    input  logic [REG_W-1:0] set_reg,
    input  logic             clr_en,
    input  logic [WID_W-1:0] clr_wid,
    input  logic [REG_W-1:0] clr_reg
);
    logic [NUM_REGS-1:0] ready_q [NUM_WARPS];
    logic ok1, ok2;

    // Source check: register 0 exempt, table bit or writeback bypass.
    always_comb begin
        ok1 = (q_rs1 == '0) || ready_q[q_wid][q_rs1] ||
              (set_en && set_wid == q_wid && set_reg == q_rs1);
        ok2 = (q_rs2 == '0) || ready_q[q_wid][q_rs2] ||
              (set_en && set_wid == q_wid && set_reg == q_rs2);
        q_ok = ok1 && ok2;
    end

    for (genvar gw = 0; gw < NUM_WARPS; gw++) begin : g_row
        // Row update for one warp: reset to ready, clear on dispatch, set on writeback.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ready_q[gw] <= '1;
            end else begin
                for (int r = 0; r < NUM_REGS; r++) begin
                    if (clr_en && clr_wid == WID_W'(gw) && clr_reg == REG_W'(r))
                        ready_q[gw][r] <= 1'b0;
                    else if (set_en && set_wid == WID_W'(gw) && set_reg == REG_W'(r))
                        ready_q[gw][r] <= 1'b1;
                end
            end
        end
    end

    // R3
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !ready_q[$past(clr_wid)][$past(clr_reg)]);

    // R4
    set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !(clr_en && clr_wid == set_wid && clr_reg == set_reg))
        |=> ready_q[$past(set_wid)][$past(set_reg)]);
endmodule

// File: rtl/sbi_issue_slot.sv
// Single issue slot with the dispatch decision.
// What it does: holds one instruction, routes it to the execute or the
// load/store path when its sources are ready, and reloads on the same edge.
// Assumes: the upstream stage holds its offer while issue_stall is high.
module sbi_issue_slot #(
    parameter int WID_W = 5,
    parameter int REG_W = 5,
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WID_W-1:0] in_wid,
    input  logic [REG_W-1:0] in_rs1,
    input  logic [REG_W-1:0] in_rs2,
    input  logic             in_rd_en,
    input  logic [REG_W-1:0] in_rd,
    input  logic             in_is_mem,
    input  logic             in_release,
    input  logic [LAT_W-1:0] in_mem_lat,
    input  logic             src_ok,
    input  logic             lsu_busy,
    output logic [WID_W-1:0] s_wid,
    output logic [REG_W-1:0] s_rs1,
    output logic [REG_W-1:0] s_rs2,
    output logic             s_rd_en,
    output logic [REG_W-1:0] s_rd,
    output logic             s_release,
    output logic [LAT_W-1:0] s_lat,
    output logic             disp_exe,
    output logic             disp_mem,
    output logic             stall
);
    logic s_valid, s_is_mem, load;

    // Dispatch decision and stall back to decode.
    always_comb begin
        disp_exe = s_valid && !s_is_mem && src_ok;
        disp_mem = s_valid && s_is_mem && src_ok && !lsu_busy;
        stall    = s_valid && !(disp_exe || disp_mem);
        load     = in_valid && !stall;
    end

    // Slot register: load when free or dispatching, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_valid   <= 1'b0;
            s_wid     <= '0;
            s_rs1     <= '0;
            s_rs2     <= '0;
            s_rd_en   <= 1'b0;
            s_rd      <= '0;
            s_is_mem  <= 1'b0;
            s_release <= 1'b0;
            s_lat     <= '0;
        end else if (load) begin
            s_valid   <= 1'b1;
            s_wid     <= in_wid;
            s_rs1     <= in_rs1;
            s_rs2     <= in_rs2;
            s_rd_en   <= in_rd_en;
            s_rd      <= in_rd;
            s_is_mem  <= in_is_mem;
            s_release <= in_release;
            s_lat     <= in_mem_lat;
        end else if (disp_exe || disp_mem) begin
            s_valid   <= 1'b0;
        end
    end

    // R11
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> s_valid && $stable(s_wid) && $stable(s_rd) && $stable(s_rs1) && $stable(s_is_mem));
endmodule

// File: rtl/sbi_lsu_track.sv
// Load/store occupancy tracker.
// What it does: holds the one in-flight memory instruction, counts its
// latency down and reports when it is busy or has a result to write.
// Assumes: a dispatch arrives only when busy is low.
module sbi_lsu_track #(
    parameter int WID_W = 5,
    parameter int REG_W = 5,
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp,
    input  logic [WID_W-1:0] d_wid,
    input  logic             d_rd_en,
    input  logic [REG_W-1:0] d_rd,
    input  logic             d_release,
    input  logic [LAT_W-1:0] d_lat,
    input  logic             granted,
    output logic             done,
    output logic             busy,
    output logic [WID_W-1:0] m_wid,
    output logic [REG_W-1:0] m_rd,
    output logic             m_release
);
    logic             m_valid, m_rd_en;
    logic [LAT_W-1:0] cnt_q;

    // Result ready for writeback, and busy when counting or blocked at the port.
    always_comb begin
        done = m_valid && (cnt_q == '0) && m_rd_en && (m_rd != '0);
        busy = m_valid && ((cnt_q != '0) || (done && !granted));
    end

    // Entry register: load on dispatch, count down, retire when written or nothing to write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_valid   <= 1'b0;
            m_rd_en   <= 1'b0;
            m_wid     <= '0;
            m_rd      <= '0;
            m_release <= 1'b0;
            cnt_q     <= '0;
        end else if (disp) begin
            m_valid   <= 1'b1;
            m_rd_en   <= d_rd_en;
            m_wid     <= d_wid;
            m_rd      <= d_rd;
            m_release <= d_release;
            cnt_q     <= d_lat;
        end else if (m_valid) begin
            if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
            else if (!done || granted)
                m_valid <= 1'b0;
        end
    end

    // R10
    lat_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && cnt_q != '0 && !disp) |=> cnt_q == LAT_W'($past(cnt_q) - 1'b1));

    // R9
    blocked_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !granted) |=> m_valid && $stable(m_rd) && $stable(m_wid));
endmodule

// File: rtl/sbi_wb_arbiter.sv
// Execute stage register and writeback port arbiter.
// What it does: captures execute dispatches for one cycle, then gives the
// port to the execute result first and to a finished load otherwise.
// Assumes: the execute path never back-pressures.
module sbi_wb_arbiter
    import sbi_pkg::*;
#(
    parameter int WID_W = 5,
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_exe,
    input  logic [WID_W-1:0] d_wid,
    input  logic             d_rd_en,
    input  logic [REG_W-1:0] d_rd,
    input  logic             d_release,
    input  logic             mem_done,
    input  logic [WID_W-1:0] mem_wid,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_release,
    output logic             mem_grant,
    output logic             wb_valid,
    output logic [WID_W-1:0] wb_wid,
    output logic             wb_rd_en,
    output logic [REG_W-1:0] wb_rd,
    output logic             wb_release,
    output logic             wb_from_mem
);
    logic             x_valid, x_rd_en, x_release, exe_claim;
    logic [WID_W-1:0] x_wid;
    logic [REG_W-1:0] x_rd;
    wb_src_e          pick;

    // Fixed-priority selection: execute result first.
    always_comb begin
        exe_claim = x_valid && (x_release || (x_rd_en && x_rd != '0));
        mem_grant = mem_done && !exe_claim;
        if (exe_claim)      pick = WB_FROM_EXE;
        else if (mem_grant) pick = WB_FROM_MEM;
        else                pick = WB_IDLE;
    end

    // Execute stage register: one cycle between dispatch and writeback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_valid   <= 1'b0;
            x_wid     <= '0;
            x_rd_en   <= 1'b0;
            x_rd      <= '0;
            x_release <= 1'b0;
        end else begin
            x_valid   <= disp_exe;
            x_wid     <= d_wid;
            x_rd_en   <= d_rd_en;
            x_rd      <= d_rd;
            x_release <= d_release;
        end
    end

    // Writeback record register loaded from the winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid    <= 1'b0;
            wb_wid      <= '0;
            wb_rd_en    <= 1'b0;
            wb_rd       <= '0;
            wb_release  <= 1'b0;
            wb_from_mem <= 1'b0;
        end else begin
            unique case (pick)
                WB_FROM_EXE: begin
                    wb_valid    <= 1'b1;
                    wb_wid      <= x_wid;
                    wb_rd_en    <= x_rd_en && (x_rd != '0);
                    wb_rd       <= x_rd;
                    wb_release  <= x_release;
                    wb_from_mem <= 1'b0;
                end
                WB_FROM_MEM: begin
                    wb_valid    <= 1'b1;
                    wb_wid      <= mem_wid;
                    wb_rd_en    <= 1'b1;
                    wb_rd       <= mem_rd;
                    wb_release  <= mem_release;
                    wb_from_mem <= 1'b1;
                end
                default: begin
                    wb_valid    <= 1'b0;
                    wb_rd_en    <= 1'b0;
                    wb_release  <= 1'b0;
                    wb_from_mem <= 1'b0;
                end
            endcase
        end
    end

    // R9
    exe_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_done && x_valid && x_rd_en && x_rd != '0) |=> wb_valid && !wb_from_mem);

    // R7
    no_claim_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!x_valid && !mem_done) |=> !wb_valid);
endmodule

// File: rtl/warp_issue_sb.sv
// Top of the warp scoreboard issue block.
// What it does: ties the ready table, the issue slot, the load/store tracker
// and the writeback arbiter; all paths settle downstream-first in one cycle.
// Assumes: NUM_WARPS and NUM_REGS are powers of two of at least 2.
module warp_issue_sb #(
    parameter int NUM_WARPS = 32,
    parameter int NUM_REGS  = 32,
    parameter int LAT_W     = 8,
    localparam int WID_W    = $clog2(NUM_WARPS),
    localparam int REG_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WID_W-1:0] in_wid,
    input  logic [REG_W-1:0] in_rs1,
    input  logic [REG_W-1:0] in_rs2,
    input  logic             in_rd_en,
    input  logic [REG_W-1:0] in_rd,
    input  logic             in_is_mem,
    input  logic             in_release,
    input  logic [LAT_W-1:0] in_mem_lat,
    output logic             issue_stall,
    output logic             exe_disp_valid,
    output logic             mem_disp_valid,
    output logic             wb_valid,
    output logic [WID_W-1:0] wb_wid,
    output logic             wb_rd_en,
    output logic [REG_W-1:0] wb_rd,
    output logic             wb_release,
    output logic             wb_from_mem
);
    logic [WID_W-1:0] s_wid, m_wid;
    logic [REG_W-1:0] s_rs1, s_rs2, s_rd, m_rd;
    logic [LAT_W-1:0] s_lat;
    logic             s_rd_en, s_release, m_release;
    logic             src_ok, lsu_busy, lsu_done, mem_grant, set_en, clr_en;

    // Ready-table update controls.
    always_comb begin
        set_en = wb_valid && wb_rd_en && (wb_rd != '0);
        clr_en = (exe_disp_valid || mem_disp_valid) && s_rd_en;
    end

    sbi_ready_table #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .WID_W(WID_W), .REG_W(REG_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .q_wid(s_wid), .q_rs1(s_rs1), .q_rs2(s_rs2), .q_ok(src_ok),
        .set_en(set_en), .set_wid(wb_wid), .set_reg(wb_rd),
        .clr_en(clr_en), .clr_wid(s_wid), .clr_reg(s_rd)
    );

    sbi_issue_slot #(.WID_W(WID_W), .REG_W(REG_W), .LAT_W(LAT_W)) u_slot (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_wid(in_wid), .in_rs1(in_rs1), .in_rs2(in_rs2),
        .in_rd_en(in_rd_en), .in_rd(in_rd), .in_is_mem(in_is_mem),
        .in_release(in_release), .in_mem_lat(in_mem_lat),
        .src_ok(src_ok), .lsu_busy(lsu_busy),
        .s_wid(s_wid), .s_rs1(s_rs1), .s_rs2(s_rs2), .s_rd_en(s_rd_en), .s_rd(s_rd),
        .s_release(s_release), .s_lat(s_lat),
        .disp_exe(exe_disp_valid), .disp_mem(mem_disp_valid), .stall(issue_stall)
    );

    sbi_lsu_track #(.WID_W(WID_W), .REG_W(REG_W), .LAT_W(LAT_W)) u_lsu (
        .clk(clk), .rst_n(rst_n),
        .disp(mem_disp_valid), .d_wid(s_wid), .d_rd_en(s_rd_en), .d_rd(s_rd),
        .d_release(s_release), .d_lat(s_lat),
        .granted(mem_grant), .done(lsu_done), .busy(lsu_busy),
        .m_wid(m_wid), .m_rd(m_rd), .m_release(m_release)
    );

    sbi_wb_arbiter #(.WID_W(WID_W), .REG_W(REG_W)) u_wb (
        .clk(clk), .rst_n(rst_n),
        .disp_exe(exe_disp_valid), .d_wid(s_wid), .d_rd_en(s_rd_en), .d_rd(s_rd),
        .d_release(s_release),
        .mem_done(lsu_done), .mem_wid(m_wid), .mem_rd(m_rd), .mem_release(m_release),
        .mem_grant(mem_grant),
        .wb_valid(wb_valid), .wb_wid(wb_wid), .wb_rd_en(wb_rd_en), .wb_rd(wb_rd),
        .wb_release(wb_release), .wb_from_mem(wb_from_mem)
    );

    // R6
    mem_waits_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsu_done && !mem_grant) |-> !mem_disp_valid);
endmodule

// File: tb/warp_issue_sb_bench.sv
module warp_issue_sb_bench;
    localparam int NW = 4;
    localparam int NR = 8;
    localparam int LW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [1:0] in_wid = '0;
    logic [2:0] in_rs1 = '0, in_rs2 = '0, in_rd = '0;
    logic in_rd_en = 1'b0, in_is_mem = 1'b0, in_release = 1'b0;
    logic [LW-1:0] in_mem_lat = '0;
    logic issue_stall, exe_disp_valid, mem_disp_valid;
    logic wb_valid, wb_rd_en, wb_release, wb_from_mem;
    logic [1:0] wb_wid;
    logic [2:0] wb_rd;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [7:0] expq [$];

    always #2.5 clk = ~clk;

    warp_issue_sb #(.NUM_WARPS(NW), .NUM_REGS(NR), .LAT_W(LW)) u_warp_issue_sb (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_wid(in_wid), .in_rs1(in_rs1), .in_rs2(in_rs2),
        .in_rd_en(in_rd_en), .in_rd(in_rd), .in_is_mem(in_is_mem),
        .in_release(in_release), .in_mem_lat(in_mem_lat),
        .issue_stall(issue_stall), .exe_disp_valid(exe_disp_valid),
        .mem_disp_valid(mem_disp_valid), .wb_valid(wb_valid), .wb_wid(wb_wid),
        .wb_rd_en(wb_rd_en), .wb_rd(wb_rd), .wb_release(wb_release),
        .wb_from_mem(wb_from_mem)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Record layout: {from_mem, release, rd_en, rd[2:0], wid[1:0]}
    function automatic logic [7:0] pack(input bit m, input bit rel, input bit en,
                                        input int rd, input int w);
        return {m, rel, en, (en ? 3'(rd) : 3'd0), 2'(w)};
    endfunction

    task automatic expect_wb(input bit m, input bit rel, input bit en, input int rd, input int w);
        expq.push_back(pack(m, rel, en, rd, w));
    endtask

    // Monitor: every record leaving the port is popped and compared (R7, R8, R9).
    always @(negedge clk) begin
        if (rst_n && wb_valid) begin
            logic [7:0] act;
            act = pack(wb_from_mem, wb_release, wb_rd_en, int'(wb_rd), int'(wb_wid));
            if (expq.size() == 0) begin
                chk(1'b0, "R7/R8 unexpected record", int'(act), 0);
            end else begin
                logic [7:0] e;
                e = expq.pop_front();
                chk(act == e, "R7/R8/R9 record order", int'(act), int'(e));
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Driver: offers one instruction and holds it until accepted.
    task automatic send(input int w, input int rs1, input int rs2, input bit en, input int rd,
                        input bit mem, input bit rel, input int lat);
        bit ok;
        @(negedge clk);
        in_valid = 1'b1; in_wid = 2'(w); in_rs1 = 3'(rs1); in_rs2 = 3'(rs2);
        in_rd_en = en; in_rd = 3'(rd); in_is_mem = mem; in_release = rel;
        in_mem_lat = LW'(lat);
        ok = !issue_stall;
        @(posedge clk);
        while (!ok) begin
            @(negedge clk);
            ok = !issue_stall;
            @(posedge clk);
        end
    endtask

    task automatic drain(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(issue_stall == 0, "R1 stall at reset", int'(issue_stall), 0);
        chk(exe_disp_valid == 0 && mem_disp_valid == 0, "R1 dispatch at reset",
            int'(exe_disp_valid | mem_disp_valid), 0);
        chk(wb_valid == 0, "R1 wb at reset", int'(wb_valid), 0);
        rst_n = 1'b1;

        // R1/R5: first instruction reads high registers, dispatches next cycle
        expect_wb(0, 0, 1, 7, 3);
        send(3, 7, 6, 1, 7, 0, 0, 0);
        @(negedge clk); in_valid = 1'b0;
        chk(exe_disp_valid == 1, "R1 R5 dispatch next cycle", int'(exe_disp_valid), 1);
        @(negedge clk);
        chk(wb_valid == 0, "R5 wb not yet", int'(wb_valid), 0);
        @(negedge clk);
        chk(wb_valid == 1 && wb_rd == 3'd7, "R5 wb two after dispatch", int'(wb_rd), 7);
        drain(4);

        // R3/R4/R11: same-warp dependency; a foreign offer during stall is ignored
        expect_wb(0, 0, 1, 5, 1);
        expect_wb(0, 0, 1, 6, 1);
        send(1, 0, 0, 1, 5, 0, 0, 0);
        send(1, 5, 0, 1, 6, 0, 0, 0);            // accepted on the dispatch edge (R11)
        @(negedge clk);
        in_valid = 1'b1; in_wid = 2'd1; in_rs1 = '0; in_rs2 = '0;
        in_rd_en = 1'b1; in_rd = 3'd7; in_is_mem = 1'b0; in_release = 1'b0;
        chk(issue_stall == 1, "R3 reader stalls", int'(issue_stall), 1);
        @(negedge clk); in_valid = 1'b0;
        chk(issue_stall == 0 && exe_disp_valid == 1, "R4 bypass dispatch",
            int'(exe_disp_valid), 1);
        chk(wb_valid == 1 && wb_rd == 3'd5, "R4 producer record", int'(wb_rd), 5);
        @(negedge clk); @(negedge clk);
        chk(wb_valid == 1 && wb_rd == 3'd6, "R11 slot kept contents", int'(wb_rd), 6);
        drain(4);

        // R3: other warp reading the same register number is not blocked
        expect_wb(0, 0, 1, 5, 1);
        expect_wb(0, 0, 1, 1, 2);
        send(1, 0, 0, 1, 5, 0, 0, 0);
        send(2, 5, 0, 1, 1, 0, 0, 0);
        @(negedge clk); in_valid = 1'b0;
        chk(issue_stall == 0 && exe_disp_valid == 1, "R3 other warp free",
            int'(issue_stall), 0);
        drain(4);

        // R2/R7: destination r0 gives no record, reads of r0 never stall
        expect_wb(0, 0, 1, 3, 0);
        send(0, 0, 0, 1, 0, 0, 0, 0);
        send(0, 0, 0, 1, 3, 0, 0, 0);
        @(negedge clk); in_valid = 1'b0;
        chk(issue_stall == 0 && exe_disp_valid == 1, "R2 r0 exempt", int'(issue_stall), 0);
        drain(4);

        // R7: release without destination takes the port
        expect_wb(0, 1, 0, 0, 3);
        send(3, 0, 0, 0, 0, 0, 1, 0);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(wb_valid == 1 && wb_release == 1 && wb_rd_en == 0, "R7 release record",
            int'(wb_release), 1);
        drain(4);

        // R6/R10: load latency 3, second load waits on the busy unit
        expect_wb(1, 0, 1, 4, 0);
        expect_wb(1, 0, 1, 2, 1);
        send(0, 0, 0, 1, 4, 1, 0, 3);
        @(negedge clk);
        chk(mem_disp_valid == 1, "R10 load dispatch", int'(mem_disp_valid), 1);
        in_valid = 1'b1; in_wid = 2'd1; in_rs1 = '0; in_rs2 = '0; in_rd_en = 1'b1;
        in_rd = 3'd2; in_is_mem = 1'b1; in_release = 1'b0; in_mem_lat = '0;
        @(negedge clk); in_valid = 1'b0;
        chk(issue_stall == 1, "R6 waits on latency", int'(issue_stall), 1);
        @(negedge clk);
        chk(issue_stall == 1, "R6 still waiting", int'(issue_stall), 1);
        @(negedge clk); @(negedge clk);
        chk(wb_valid == 0, "R10 not before d+2+L", int'(wb_valid), 0);
        chk(mem_disp_valid == 1, "R6 dispatch when freed", int'(mem_disp_valid), 1);
        @(negedge clk);
        chk(wb_valid == 1 && wb_from_mem == 1 && wb_rd == 3'd4, "R10 load record",
            int'(wb_rd), 4);
        drain(4);

        // R9/R6/R8: execute beats a finished load; a store waits behind it
        expect_wb(0, 0, 1, 3, 1);
        expect_wb(1, 0, 1, 2, 0);
        send(0, 0, 0, 1, 2, 1, 0, 1);
        send(1, 0, 0, 1, 3, 0, 0, 0);
        send(2, 0, 0, 0, 0, 1, 0, 0);
        @(negedge clk); in_valid = 1'b0;
        chk(issue_stall == 1, "R6 blocked load stalls store", int'(issue_stall), 1);
        @(negedge clk);
        chk(mem_disp_valid == 1, "R6 store dispatch after load", int'(mem_disp_valid), 1);
        chk(wb_valid == 1 && wb_from_mem == 0 && wb_rd == 3'd3, "R9 execute first",
            int'(wb_from_mem), 0);
        @(negedge clk);
        chk(wb_valid == 1 && wb_from_mem == 1 && wb_rd == 3'd2, "R9 load next cycle",
            int'(wb_from_mem), 1);
        drain(6);
        chk(wb_valid == 0, "R8 store gives no record", int'(wb_valid), 0);
        chk(expq.size() == 0, "R7 all records seen", expq.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule